// File: doc/BRIEF.md
# Register-Following Chip-Select Decoder

This block drives four active-low chip-select lines for a 512-byte window that sits directly above a relocatable 512-byte register block. The register block is placed on a 2-Kbyte boundary given by the upper address bits in `reg_base`. The decode window is the second 512-byte quarter of that 2-Kbyte span. With `reg_base` = 1, the registers occupy $0800–$09FF and the window is $0A00–$0BFF. When the register block moves, the window moves with it.

A 2-bit layout field divides the window among the selects. The selects are placed in ascending address order. Each select has its own enable bit. A select goes low only while the bus-cycle strobe is high. A single-chip-mode flag holds every line high whatever the other controls say. The address path is purely combinational. The clock and reset are used only by the embedded checks.

Top module: `rf_chipsel_decoder`

## Requirements
- R1: The outputs `cs_n[3:0]` are active low. While `bus_valid` is 0, all four lines are high, and this is also the state seen after reset.
- R2: A select can assert only for an address in `[reg_base*2048 + 512, reg_base*2048 + 1023]`. The register block itself, the bytes above the window and every other 2-Kbyte span leave all lines high.
- R3: The window follows `reg_base`. For example, base 0 gives $0200–$03FF and base 31 gives $FA00–$FBFF.
- R4: With `layout` = 2'b00, `cs_n[0]` covers the whole 512-byte window.
- R5: With `layout` = 2'b01, `cs_n[0]` covers window offsets 0–255 and `cs_n[1]` covers offsets 256–511.
- R6: With `layout` = 2'b10, `cs_n[0]` covers offsets 0–255, `cs_n[1]` covers 256–383 and `cs_n[2]` covers 384–511.
- R7: With `layout` = 2'b11, select i covers offsets i*128 to i*128+127, for i = 0 to 3.
- R8: `sel_en[i]` = 0 holds `cs_n[i]` high even when its range is addressed. The other selects keep their own ranges.
- R9: The strobe gates the output combinationally. When `bus_valid` falls, the active select returns high in the same cycle, with no clock edge in between.
- R10: When `single_chip` = 1, all four lines stay high for any address, layout and enable setting.
- R11: At most one line is low at any time. A select that the chosen layout does not use never asserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset, used by the embedded checks |
| addr | input | 16 | CPU address |
| reg_base | input | 5 | Register block base, which is address bits 15:11 |
| bus_valid | input | 1 | Bus-cycle valid strobe |
| layout | input | 2 | Window split: 00 one, 01 two halves, 10 half plus two quarters, 11 four quarters |
| sel_en | input | 4 | Per-select enable, where bit i enables `cs_n[i]` |
| single_chip | input | 1 | Single-chip mode; holds all selects high |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The embedded properties check these rules on every cycle:
- No more than one line is low.
- Nothing asserts outside the window. The assertion computes the window bounds arithmetically.
- A disabled or unused select stays high.
- A low strobe or single-chip mode forces all lines high.

Only the bench scenarios can show the rest:
- Which select owns each offset under every layout.
- That the window moves correctly when `reg_base` changes.
- That the edges of the window, and of each slice inside it, fall on the right bytes.
- That an enabled select really does go low.

// File: rtl/rfcs_pkg.sv
// Shared types for the register-following chip-select decoder.
// Assumes exactly four selects and a window split into four equal slices.
package rfcs_pkg;

    localparam int NUM_SEL = 4;

    // Window split. The encoding is the software-visible field value.
    typedef enum logic [1:0] {
        LAYOUT_WHOLE         = 2'b00,
        LAYOUT_HALVES        = 2'b01,
        LAYOUT_HALF_QUARTERS = 2'b10,
        LAYOUT_QUARTERS      = 2'b11
    } layout_e;

endpackage

// File: rtl/rfcs_window_match.sv
// Detects whether an address falls in the window that sits one window-size
// above the aligned register block, and returns the offset inside it.
// Assumes that BASE_AW > REGION_AW, so the window lies in the same aligned span.
module rfcs_window_match #(
    parameter int ADDR_W    = 16,
    parameter int BASE_AW   = 11,
    parameter int REGION_AW = 9
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-BASE_AW-1:0] reg_base,
    output logic                      hit,
    output logic [REGION_AW-1:0]      offset
);
    localparam int SLOT_W = BASE_AW - REGION_AW;
    localparam logic [SLOT_W-1:0] WINDOW_SLOT = SLOT_W'(1);

    logic span_eq;
    logic slot_eq;

    // Purpose: compare the upper bits with the base, and the slot bits with the window slot.
    always_comb begin
        span_eq = (addr[ADDR_W-1:BASE_AW] == reg_base);
        slot_eq = (addr[BASE_AW-1:REGION_AW] == WINDOW_SLOT);
        hit     = span_eq && slot_eq;
        offset  = addr[REGION_AW-1:0];
    end

endmodule

// File: rtl/rfcs_layout_map.sv
// Maps a window offset to a one-hot select vector according to the layout.
// The selects are assigned in ascending address order. It assumes four slices.
module rfcs_layout_map
    import rfcs_pkg::*;
#(
    parameter int REGION_AW = 9
) (
    input  layout_e              layout,
    input  logic [REGION_AW-1:0] offset,
    output logic [NUM_SEL-1:0]   sel_oh
);
    localparam int IDX_W = $clog2(NUM_SEL);

    logic [IDX_W-1:0] slice;
    logic [IDX_W-1:0] idx;

    // Purpose: choose the select index from the slice number and the layout.
    always_comb begin
        slice = offset[REGION_AW-1 -: IDX_W];
        unique case (layout)
            LAYOUT_WHOLE:         idx = '0;
            LAYOUT_HALVES:        idx = {1'b0, slice[1]};
            LAYOUT_HALF_QUARTERS: idx = slice[1] ? {slice[0], ~slice[0]} : '0;
            LAYOUT_QUARTERS:      idx = slice;
            default:              idx = '0;
        endcase
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_oh
        assign sel_oh[i] = (idx == IDX_W'(i));
    end

endmodule

// File: rtl/rfcs_pin_drive.sv
// Combines a window hit, a one-hot select vector, the per-select enables,
// the bus strobe and single-chip mode into active-low pin levels.
// It assumes that sel_oh carries at most one bit.
module rfcs_pin_drive
    import rfcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic [NUM_SEL-1:0] sel_oh,
    input  logic [NUM_SEL-1:0] sel_en,
    input  logic               bus_valid,
    input  logic               single_chip,
    output logic [NUM_SEL-1:0] cs_n
);
    logic gate;

    // Purpose: allow assertion only in an expanded-mode bus cycle that hits the window.
    always_comb gate = hit && bus_valid && !single_chip;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_pin
        assign cs_n[i] = ~(gate & sel_oh[i] & sel_en[i]);

        // R8
        property disabled_p;
            @(posedge clk) disable iff (!rst_n) !sel_en[i] |-> cs_n[i];
        endproperty
        disabled_high_chk: assert property (disabled_p);
    end

    // R10
    single_chip_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_chip |-> (cs_n == '1));

    // R1 R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (cs_n == '1));

    // R11
    one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

endmodule

// File: rtl/rf_chipsel_decoder.sv
// Top of the register-following chip-select decoder. It decodes the window
// above the relocatable register block into up to four active-low selects.
// The address path is combinational. clk and rst_n serve the checks only.
module rf_chipsel_decoder
    import rfcs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_AW   = 11,
    parameter int REGION_AW = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-BASE_AW-1:0] reg_base,
    input  logic                      bus_valid,
    input  logic [1:0]                layout,
    input  logic [NUM_SEL-1:0]        sel_en,
    input  logic                      single_chip,
    output logic [NUM_SEL-1:0]        cs_n
);
    logic                 win_hit;
    logic [REGION_AW-1:0] win_off;
    logic [NUM_SEL-1:0]   sel_oh;
    layout_e              layout_q;

    // Purpose: give the raw field its enumerated type.
    always_comb layout_q = layout_e'(layout);

    rfcs_window_match #(
        .ADDR_W   (ADDR_W),
        .BASE_AW  (BASE_AW),
        .REGION_AW(REGION_AW)
    ) u_match (
        .addr    (addr),
        .reg_base(reg_base),
        .hit     (win_hit),
        .offset  (win_off)
    );

    rfcs_layout_map #(
        .REGION_AW(REGION_AW)
    ) u_map (
        .layout(layout_q),
        .offset(win_off),
        .sel_oh(sel_oh)
    );

    rfcs_pin_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (win_hit),
        .sel_oh     (sel_oh),
        .sel_en     (sel_en),
        .bus_valid  (bus_valid),
        .single_chip(single_chip),
        .cs_n       (cs_n)
    );

    // Arithmetic window bounds, kept independent of the bit compare in u_match.
    logic [ADDR_W:0] win_lo;
    logic [ADDR_W:0] win_hi;
    logic            in_window;
    // Purpose: compute the window bounds arithmetically for the checks.
    always_comb begin
        win_lo    = ({1'b0, reg_base, {BASE_AW{1'b0}}}) + (ADDR_W+1)'(2 ** REGION_AW);
        win_hi    = win_lo + (ADDR_W+1)'(2 ** REGION_AW);
        in_window = ({1'b0, addr} >= win_lo) && ({1'b0, addr} < win_hi);
    end

    // R2 R3
    outside_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |-> (cs_n == '1));

    // R4 R11
    whole_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == 2'b00) |-> (cs_n[3:1] == 3'b111));

    // R5 R11
    halves_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == 2'b01) |-> (cs_n[3:2] == 2'b11));

    // R6 R11
    half_quarters_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == 2'b10) |-> cs_n[3]);

endmodule

// File: tb/tb_rf_chipsel_decoder.sv
// Directed bench for the register-following chip-select decoder.
module tb_rf_chipsel_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [4:0]  reg_base = 5'd1;
    logic        bus_valid = 1'b0;
    logic [1:0]  layout = 2'b00;
    logic [3:0]  sel_en = 4'hF;
    logic        single_chip = 1'b0;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_chipsel_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .reg_base(reg_base),
        .bus_valid(bus_valid), .layout(layout), .sel_en(sel_en),
        .single_chip(single_chip), .cs_n(cs_n)
    );

    // The expected value, written from the requirements.
    function automatic logic [3:0] model(input logic [15:0] a, input logic [4:0] b,
                                         input logic [1:0] lay, input logic [3:0] en,
                                         input logic v, input logic sc);
        int off;
        int idx;
        off = int'(a) - int'(b) * 2048 - 512;
        if (!v || sc || off < 0 || off >= 512) return 4'hF;
        case (lay)
            2'b00:   idx = 0;
            2'b01:   idx = (off < 256) ? 0 : 1;
            2'b10:   idx = (off < 256) ? 0 : ((off < 384) ? 1 : 2);
            default: idx = off / 128;
        endcase
        if (!en[idx]) return 4'hF;
        return ~(4'b0001 << idx);
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (cs_n !== exp) begin
            errors++;
            $display("FAIL %s addr=%h base=%0d layout=%b en=%b: cs_n=%b expected=%b",
                     tag, addr, reg_base, layout, sel_en, cs_n, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [4:0] b, input logic [1:0] lay,
                         input logic [3:0] en, input logic v, input logic sc);
        @(negedge clk);
        addr = a; reg_base = b; layout = lay; sel_en = en; bus_valid = v; single_chip = sc;
        #1;
    endtask

    task automatic t_reset_idle();
        apply(16'h0A00, 5'd1, 2'b00, 4'hF, 1'b0, 1'b0);
        check("R1 idle after reset", 4'hF);
    endtask

    task automatic t_layout(input logic [1:0] lay, input string tag);
        for (int off = 0; off < 512; off += 32) begin
            apply(16'h0A00 + 16'(off), 5'd1, lay, 4'hF, 1'b1, 1'b0);
            check(tag, model(addr, 5'd1, lay, 4'hF, 1'b1, 1'b0));
            apply(16'h0A00 + 16'(off) + 16'd31, 5'd1, lay, 4'hF, 1'b1, 1'b0);
            check(tag, model(addr, 5'd1, lay, 4'hF, 1'b1, 1'b0));
        end
    endtask

    task automatic t_outside();
        logic [15:0] outs[6] = '{16'h0800, 16'h09FF, 16'h0C00, 16'h0FFF, 16'h1200, 16'h0200};
        foreach (outs[i]) begin
            apply(outs[i], 5'd1, 2'b11, 4'hF, 1'b1, 1'b0);
            check("R2 outside window", 4'hF);
        end
        apply(16'h0A00, 5'd1, 2'b11, 4'hF, 1'b1, 1'b0);
        check("R2 low edge", 4'b1110);
        apply(16'h0BFF, 5'd1, 2'b11, 4'hF, 1'b1, 1'b0);
        check("R2 high edge", 4'b0111);
    endtask

    task automatic t_relocate();
        apply(16'h0200, 5'd0, 2'b01, 4'hF, 1'b1, 1'b0);
        check("R3 base 0 low", 4'b1110);
        apply(16'h03FF, 5'd0, 2'b01, 4'hF, 1'b1, 1'b0);
        check("R3 base 0 high", 4'b1101);
        apply(16'h0A00, 5'd0, 2'b01, 4'hF, 1'b1, 1'b0);
        check("R3 old window idle", 4'hF);
        apply(16'hFA00, 5'd31, 2'b11, 4'hF, 1'b1, 1'b0);
        check("R3 base 31 low", 4'b1110);
        apply(16'hFBFF, 5'd31, 2'b11, 4'hF, 1'b1, 1'b0);
        check("R3 base 31 high", 4'b0111);
        apply(16'hFC00, 5'd31, 2'b11, 4'hF, 1'b1, 1'b0);
        check("R3 above base 31", 4'hF);
    endtask

    task automatic t_enable();
        apply(16'h0B00, 5'd1, 2'b11, 4'b1011, 1'b1, 1'b0);
        check("R8 disabled cs2 stays high", 4'hF);
        apply(16'h0A80, 5'd1, 2'b11, 4'b1011, 1'b1, 1'b0);
        check("R8 cs1 still works", 4'b1101);
        apply(16'h0B80, 5'd1, 2'b11, 4'b1011, 1'b1, 1'b0);
        check("R8 cs3 still works", 4'b0111);
        apply(16'h0A10, 5'd1, 2'b00, 4'b1110, 1'b1, 1'b0);
        check("R8 disabled cs0", 4'hF);
    endtask

    task automatic t_strobe();
        apply(16'h0A90, 5'd1, 2'b11, 4'hF, 1'b1, 1'b0);
        check("R9 strobe high", 4'b1101);
        #1 bus_valid = 1'b0;
        #1 check("R9 strobe drop same cycle", 4'hF);
        #1 bus_valid = 1'b1;
        #1 check("R9 strobe rise same cycle", 4'b1101);
    endtask

    task automatic t_single();
        for (int lay = 0; lay < 4; lay++) begin
            apply(16'h0BC0, 5'd1, 2'(lay), 4'hF, 1'b1, 1'b1);
            check("R10 single chip", 4'hF);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_idle();
        t_layout(2'b00, "R4 R11 whole");
        t_layout(2'b01, "R5 R11 halves");
        t_layout(2'b10, "R6 R11 half plus quarters");
        t_layout(2'b11, "R7 R11 quarters");
        t_outside();
        t_relocate();
        t_enable();
        t_strobe();
        t_single();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: done=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule